// File: doc/BRIEF.md
# Viterbi Path-Metric Update Array

This block keeps the 64 path metrics of a rate-1/2, constraint-length-7 convolutional decoder and advances them by one trellis step each time a pair of signed soft bits is handed in. For every step it runs the 32 radix-2 add-compare-select butterflies in sequence, one per clock. Each new metric is the larger of two candidates. The new metrics go into the free half of a ping-pong store. The 64 survivor decisions leave the block as four 16-bit words, and a separate traceback unit consumes them.

A `start` pulse opens a frame. It loads the starting metric set, which favours state 0. After that, each accepted `in_valid`/`in_ready` handshake processes one step. The metrics are kept in 16-bit signed form. They stay in range because a common offset is removed whenever the state-0 metric climbs past a threshold. The offset shifts every metric by the same amount, so it does not change any decision.

Top module: `vit_acs_array`

## Requirements
- R1: After reset `in_ready` and `dec_valid` are 0, and no step is accepted and no word is produced until a `start` pulse has been taken.
- R2: A `start` taken while idle sets the metric of state 0 to 64 and the other 63 metrics to 0. `in_ready` is 1 in the cycle after that edge.
- R3: Soft inputs are 8-bit two's complement and are sign-extended to the 16-bit metric width. For butterfly j, let c0 = parity(2j AND 133 octal) and c1 = parity(2j AND 171 octal). The branch value T is a+b when c0 equals c1, and a−b otherwise (a = `soft_a`, b = `soft_b`). The butterfly is direct when c0 = 0 and reversed when c0 = 1.
- R4: Butterfly j reads the old metrics of states 2j and 2j+1 and writes new states j and j+32. In the direct form, new(j) = max(old(2j)+T, old(2j+1)−T) and new(j+32) = max(old(2j)−T, old(2j+1)+T). The reversed form uses −T in place of T.
- R5: A decision bit is 1 when the first candidate (the one built from old(2j)) is less than or equal to the second. On a tie the bit is therefore 1 and the odd predecessor survives.
- R6: Each step emits four words. Word k (`dec_sel` = k) covers butterflies 8k to 8k+7. Its bit 15−2i is the decision for state 8k+i, and bit 14−2i is the decision for state 8k+i+32.
- R7: Counting rising edges from the edge that accepts a step, word k is presented for one cycle after edge 9+8k. `in_ready` is 0 from the accepting edge until it returns to 1 after edge 33.
- R8: The metrics written in one step are the old metrics of the next step, so decisions over many steps follow the unbounded-precision recursion.
- R9: When the state-0 metric of a step is at least 16384, 16384 is subtracted from every metric before the next step. Long runs of full-scale inputs therefore never overflow and never alter a decision.
- R10: A `start` pulse that arrives while a step is in progress is ignored, and the metrics carry on unchanged.
- R11: A `start` taken between steps of a running frame re-applies the state-0 bias and discards the accumulated metrics.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start: load the initial metric set |
| in_valid | input | 1 | A soft-bit pair is offered |
| soft_a | input | 8 | First soft bit, signed |
| soft_b | input | 8 | Second soft bit, signed |
| in_ready | output | 1 | The block can take a step |
| dec_valid | output | 1 | `dec_word` holds a decision word |
| dec_sel | output | 2 | Index of the word within its step |
| dec_word | output | 16 | Packed survivor decisions |

## Verification
A step accepted on rising edge N produces its word k after edge N+9+8k, and `in_ready` returns after edge N+33. The bench's reference model records the accepting edge number and queues the four expected words with those due edges. At every falling edge it compares `in_ready`, `dec_valid`, `dec_sel` and `dec_word` against the model. Between due edges `dec_valid` must stay 0. The model keeps its metrics as 64-bit integers with no normalisation. A word that differs after hundreds of full-scale steps therefore shows a wrap or a faulty offset.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_DRAIN = 2'd2
  } acs_state_t;

  // Butterfly kind: bit 1 selects the difference branch value, bit 0 the
  // reversed sign form. Both come from the coded pair of the even
  // predecessor with a zero input bit.
  function automatic logic [1:0] bfly_kind(input int unsigned j,
                                           input logic [31:0] gen_a,
                                           input logic [31:0] gen_b);
    logic [31:0] sreg;
    logic        c0;
    logic        c1;
    sreg = 32'(2 * j);
    c0   = ^(sreg & gen_a);
    c1   = ^(sreg & gen_b);
    return {c0 ^ c1, c0};
  endfunction

endpackage

// File: rtl/vit_metric_bank.sv
module vit_metric_bank #(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port memory with a registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vit_acs_bfly.sv
module vit_acs_bfly #(
  parameter int MET_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [MET_W-1:0] old_e,
  input  logic signed [MET_W-1:0] old_o,
  input  logic signed [MET_W-1:0] t_in,
  input  logic                    rev,
  output logic signed [MET_W-1:0] new_lo,
  output logic signed [MET_W-1:0] new_hi,
  output logic                    d_lo,
  output logic                    d_hi
);
  localparam int XW = MET_W + 2;

  logic signed [XW-1:0] ew, ow, tw, ts;
  logic signed [XW-1:0] lo_a, lo_b, hi_a, hi_b, lo_w, hi_w;
  logic                 ovf_lo, ovf_hi;

  always_comb begin
    ew   = old_e;
    ow   = old_o;
    tw   = t_in;
    ts   = rev ? -tw : tw;
    lo_a = ew + ts;
    lo_b = ow - ts;
    hi_a = ew - ts;
    hi_b = ow + ts;
    d_lo = (lo_a <= lo_b);
    d_hi = (hi_a <= hi_b);
    lo_w = d_lo ? lo_b : lo_a;
    hi_w = d_hi ? hi_b : hi_a;
    new_lo = lo_w[MET_W-1:0];
    new_hi = hi_w[MET_W-1:0];
    ovf_lo = !((&lo_w[XW-1:MET_W-1]) || !(|lo_w[XW-1:MET_W-1]));
    ovf_hi = !((&hi_w[XW-1:MET_W-1]) || !(|hi_w[XW-1:MET_W-1]));
  end

  // Survivor metrics must fit the metric width (R9).
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    en |-> (!ovf_lo && !ovf_hi));
endmodule

// File: rtl/vit_dec_packer.sv
module vit_dec_packer #(
  parameter int WORD_W = 16,
  parameter int SW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              last,
  input  logic [SW-1:0]     sel,
  input  logic              d_lo,
  input  logic              d_hi,
  output logic              valid_o,
  output logic [SW-1:0]     sel_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int SHW = WORD_W - 2;

  logic [SHW-1:0] shreg;
  logic [SW-1:0]  prev_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      sel_o    <= '0;
      word_o   <= '0;
      shreg    <= '0;
      prev_sel <= '0;
    end else begin
      valid_o <= 1'b0;
      if (en) begin
        if (last) begin
          word_o  <= {shreg, d_lo, d_hi};
          sel_o   <= sel;
          valid_o <= 1'b1;
        end else begin
          shreg <= {shreg[SHW-3:0], d_lo, d_hi};
        end
      end
      if (valid_o) prev_sel <= sel_o;
    end
  end

  // Words of one step are spaced apart, never back to back (R6).
  p_word_gap_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // Word indices climb by one inside a step (R6).
  p_sel_order_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && sel_o != '0) |-> (sel_o == SW'(prev_sel + 1'b1)));
endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array
  import vit_acs_pkg::*;
#(
  parameter int          K           = 7,
  parameter int          SOFT_W      = 8,
  parameter int          MET_W       = 16,
  parameter int          WORD_W      = 16,
  parameter logic [31:0] POLY_A      = 32'o133,
  parameter logic [31:0] POLY_B      = 32'o171,
  parameter int          BIAS        = 64,
  parameter int          NORM_THRESH = 16384,
  parameter int          NORM_OFFSET = 16384
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       start,
  input  logic                                       in_valid,
  input  logic [SOFT_W-1:0]                          soft_a,
  input  logic [SOFT_W-1:0]                          soft_b,
  output logic                                       in_ready,
  output logic                                       dec_valid,
  output logic [$clog2((1<<(K-2))*2/WORD_W)-1:0]     dec_sel,
  output logic [WORD_W-1:0]                          dec_word
);
  localparam int NS    = 1 << (K - 1);
  localparam int NB    = NS / 2;
  localparam int JW    = K - 2;
  localparam int IW    = K - 3;
  localparam int AW    = IW + 1;
  localparam int BPW   = WORD_W / 2;
  localparam int NWORD = NB / BPW;
  localparam int SW    = $clog2(NWORD);
  localparam int LW    = JW - SW;
  localparam int NBANK = 4;
  localparam logic signed [MET_W-1:0] BIAS_M = MET_W'(BIAS);
  localparam logic signed [MET_W-1:0] THR_M  = MET_W'(NORM_THRESH);
  localparam logic signed [MET_W-1:0] OFS_M  = MET_W'(NORM_OFFSET);

  acs_state_t st;
  logic       rdy_q, init_done, fresh, norm_pend, norm_hit, rd_pp;
  logic       jp_vld;
  logic [JW-1:0] rd_j, jp;
  logic signed [MET_W-1:0] t_sum, t_diff;
  logic signed [MET_W-1:0] a_x, b_x;
  logic       acc;

  // Per-butterfly branch kind, computed from the generator pair
  logic [1:0] kind [NB];
  for (genvar gj = 0; gj < NB; gj++) begin : g_kind
    assign kind[gj] = bfly_kind(gj, POLY_A, POLY_B);
  end

  assign a_x      = {{(MET_W-SOFT_W){soft_a[SOFT_W-1]}}, soft_a};
  assign b_x      = {{(MET_W-SOFT_W){soft_b[SOFT_W-1]}}, soft_b};
  assign in_ready = rdy_q;
  assign acc      = in_valid && rdy_q;

  // Step sequencer: one read per cycle, writes trail by one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rdy_q     <= 1'b0;
      init_done <= 1'b0;
      fresh     <= 1'b0;
      norm_pend <= 1'b0;
      rd_pp     <= 1'b0;
      rd_j      <= '0;
      jp        <= '0;
      jp_vld    <= 1'b0;
      t_sum     <= '0;
      t_diff    <= '0;
    end else begin
      jp_vld <= (st == ST_READ);
      jp     <= rd_j;
      case (st)
        ST_IDLE: begin
          if (start) begin
            init_done <= 1'b1;
            fresh     <= 1'b1;
            norm_pend <= 1'b0;
            rdy_q     <= 1'b1;
          end
          if (acc) begin
            st     <= ST_READ;
            rdy_q  <= 1'b0;
            rd_j   <= '0;
            t_sum  <= a_x + b_x;
            t_diff <= a_x - b_x;
          end
        end
        ST_READ: begin
          rd_j <= rd_j + 1'b1;
          if (rd_j == JW'(NB - 1)) st <= ST_DRAIN;
        end
        ST_DRAIN: begin
          st        <= ST_IDLE;
          rdy_q     <= 1'b1;
          rd_pp     <= ~rd_pp;
          fresh     <= 1'b0;
          norm_pend <= norm_hit;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Metric store: four banks split by the state's top and bottom bits,
  // so each butterfly hits each bank at most once for read and write.
  logic [MET_W-1:0]        rdq [NBANK];
  logic signed [MET_W-1:0] new_lo, new_hi;
  logic                    d_lo, d_hi;

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    localparam logic PB = 1'(gb % 2);
    localparam logic HB = 1'(gb / 2);
    logic             we_b;
    logic [MET_W-1:0] wd_b;
    assign we_b = jp_vld && (jp[0] == PB);
    assign wd_b = HB ? new_hi : new_lo;
    vit_metric_bank #(.W(MET_W), .AW(AW)) u_bank (
      .clk   (clk),
      .we    (we_b),
      .waddr ({~rd_pp, jp[JW-1:1]}),
      .wdata (wd_b),
      .raddr ({rd_pp, rd_j[IW-1:0]}),
      .rdata (rdq[gb])
    );
  end

  // Old-metric conditioning: frame bias, then pending offset removal
  logic signed [MET_W-1:0] mem_e, mem_o, old_e, old_o, t_sel;
  logic                    rev_sel;

  always_comb begin
    mem_e = jp[JW-1] ? rdq[2] : rdq[0];
    mem_o = jp[JW-1] ? rdq[3] : rdq[1];
    if (fresh) begin
      old_e = (jp == '0) ? BIAS_M : '0;
      old_o = '0;
    end else if (norm_pend) begin
      old_e = mem_e - OFS_M;
      old_o = mem_o - OFS_M;
    end else begin
      old_e = mem_e;
      old_o = mem_o;
    end
    t_sel   = kind[jp][1] ? t_diff : t_sum;
    rev_sel = kind[jp][0];
  end

  vit_acs_bfly #(.MET_W(MET_W)) u_bfly (
    .clk    (clk),
    .rst    (rst),
    .en     (jp_vld),
    .old_e  (old_e),
    .old_o  (old_o),
    .t_in   (t_sel),
    .rev    (rev_sel),
    .new_lo (new_lo),
    .new_hi (new_hi),
    .d_lo   (d_lo),
    .d_hi   (d_hi)
  );

  // Normalisation trigger taken from the state-0 survivor of the step
  always_ff @(posedge clk) begin
    if (rst) norm_hit <= 1'b0;
    else if (jp_vld && jp == '0) norm_hit <= (new_lo >= THR_M);
  end

  vit_dec_packer #(.WORD_W(WORD_W), .SW(SW)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .en      (jp_vld),
    .last    (&jp[LW-1:0]),
    .sel     (jp[JW-1:LW]),
    .d_lo    (d_lo),
    .d_hi    (d_hi),
    .valid_o (dec_valid),
    .sel_o   (dec_sel),
    .word_o  (dec_word)
  );

  // Nothing is accepted before a frame has been opened (R1).
  p_no_ready_before_start_r1: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !in_ready);

  // An idle start opens a frame with the bias set (R2).
  p_init_r2: assert property (@(posedge clk) disable iff (rst)
    (start && st == ST_IDLE) |=> (in_ready && fresh && init_done));

  // Taking a step drops ready on the next cycle (R7).
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // A start inside a step leaves the metric conditioning untouched (R10).
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (start && st == ST_READ) |=> ($stable(fresh) && $stable(norm_pend)));
endmodule

// File: tb/tb_vit_acs_array.sv
module tb_vit_acs_array;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk, rst, start, in_valid;
  logic [7:0]  soft_a, soft_b;
  logic        in_ready, dec_valid;
  logic [1:0]  dec_sel;
  logic [15:0] dec_word;

  vit_acs_array dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .soft_a(soft_a), .soft_b(soft_b), .in_ready(in_ready),
    .dec_valid(dec_valid), .dec_sel(dec_sel), .dec_word(dec_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int     n_chk = 0;
  int     n_fail = 0;
  string  ph = "R1";
  longint m_met [64];
  int     m_init, cyc, busy_until;
  int     q_due [$];
  int     q_sel [$];
  logic [15:0] q_word [$];

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)",
               req, what, act, exp, cyc);
    end
  endtask

  function automatic int par(input int v);
    return $countones(v) % 2;
  endfunction

  // Reference step with unbounded metrics (R3, R4, R5, R6, R8)
  task automatic model_step(input longint a, input longint b, input int edge_n);
    longint nm [64];
    logic [15:0] w [4];
    for (int k = 0; k < 4; k++) w[k] = '0;
    for (int j = 0; j < 32; j++) begin
      int     c0, c1, k, i;
      longint tt, t, la, lb, ha, hb;
      bit     dl, dh;
      c0 = par((2*j) & 'o133);
      c1 = par((2*j) & 'o171);
      tt = (c0 == c1) ? a + b : a - b;
      t  = c0 ? -tt : tt;
      la = m_met[2*j] + t;     lb = m_met[2*j+1] - t;
      ha = m_met[2*j] - t;     hb = m_met[2*j+1] + t;
      dl = (la <= lb);
      dh = (ha <= hb);
      nm[j]    = dl ? lb : la;
      nm[j+32] = dh ? hb : ha;
      k = j / 8;
      i = j % 8;
      w[k][15-2*i] = dl;
      w[k][14-2*i] = dh;
    end
    for (int s = 0; s < 64; s++) m_met[s] = nm[s];
    for (int k = 0; k < 4; k++) begin
      q_due.push_back(edge_n + 9 + 8*k);
      q_sel.push_back(k);
      q_word.push_back(w[k]);
    end
  endtask

  // Model update at each rising edge, from the inputs before the edge
  always @(posedge clk) begin
    bit idle_m, rdy_m;
    if (rst) begin
      cyc = 0; m_init = 0; busy_until = 0;
      q_due.delete(); q_sel.delete(); q_word.delete();
    end else begin
      idle_m = (cyc >= busy_until);
      rdy_m  = (m_init != 0) && idle_m;
      cyc    = cyc + 1;
      if (start && idle_m) begin
        m_init = 1;
        for (int s = 0; s < 64; s++) m_met[s] = (s == 0) ? 64 : 0;
      end
      if (in_valid && rdy_m) begin
        model_step(longint'($signed(soft_a)), longint'($signed(soft_b)), cyc);
        busy_until = cyc + 33;
      end
    end
  end

  // Per-cycle comparison at the falling edge (R6, R7)
  always @(negedge clk) begin
    if (!rst) begin
      check("R7", "in_ready", longint'(in_ready),
            longint'((m_init != 0) && (cyc >= busy_until)));
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        check("R7", "dec_valid", longint'(dec_valid), 1);
        check("R6", "dec_sel", longint'(dec_sel), longint'(q_sel[0]));
        check(ph, "dec_word", longint'(dec_word), longint'(q_word[0]));
        void'(q_due.pop_front());
        void'(q_sel.pop_front());
        void'(q_word.pop_front());
      end else begin
        check("R7", "dec_valid idle", longint'(dec_valid), 0);
      end
    end
  end

  task automatic step(input int a, input int b);
    soft_a   = 8'(a);
    soft_b   = 8'(b);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", MAX_CYCLES);
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; soft_a = '0; soft_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset, no step taken before start
    check("R1", "in_ready after reset", longint'(in_ready), 0);
    check("R1", "dec_valid after reset", longint'(dec_valid), 0);
    soft_a = 8'd20; soft_b = 8'd30; in_valid = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", "in_ready without start", longint'(in_ready), 0);
    in_valid = 1'b0;
    @(negedge clk);

    // R2: bias on state 0, zero inputs make every other butterfly tie (R5)
    ph = "R2";
    pulse_start();
    check("R2", "in_ready after start", longint'(in_ready), 1);
    step(0, 0);
    ph = "R5";
    step(0, 0);
    step(3, -3);

    // R3: branch kinds under sum- and difference-heavy inputs
    ph = "R3";
    step(40, -7);
    step(-100, 3);
    step(127, -128);
    step(-128, -128);
    step(1, 0);

    // R4, R8: random stream with back-to-back steps
    ph = "R8";
    for (int n = 0; n < 40; n++)
      step($urandom_range(0, 255), $urandom_range(0, 255));

    // R10: start during a step has no effect
    ph = "R10";
    fork
      step(60, -20);
      begin
        repeat (6) @(negedge clk);
        pulse_start();
      end
    join
    step(-45, 90);
    step(12, 34);

    // R11: start between steps re-biases
    ph = "R11";
    repeat (50) @(negedge clk);
    pulse_start();
    step(5, -5);
    step(-70, 70);

    // R9: long full-scale runs force several normalisations
    ph = "R9";
    for (int n = 0; n < 300; n++) step(127, 127);
    for (int n = 0; n < 250; n++) step(-128, -128);
    for (int n = 0; n < 30; n++) step(-128, 127);
    ph = "R4";
    for (int n = 0; n < 40; n++)
      step($urandom_range(0, 255), $urandom_range(0, 255));

    repeat (60) @(negedge clk);
    check("R6", "words left undelivered", longint'(q_due.size()), 0);
    summary();
    $finish;
  end
endmodule